// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

When a transfer is cut short (reset, crash, lost power on the host side), a slave can be left halfway through a byte, holding SDA low and waiting for clocks that never come. This block sits beside the normal I2C controller and frees such a bus. On a start strobe it first waits for the controller's busy flag to clear, up to a bounded window. It then decides whether intervention is needed: a busy flag that never cleared, or SDA sampled low, means the bus is stuck.

To recover, it claims the pins through an ownership select that steers the pad mux, drives SCL low for one delay interval, and then clocks SCL through full high/low pulses. Before each pulse it samples SDA and stops as soon as the slave lets go, with a fixed cap on the pulse count. It always finishes with SCL released high for one further interval. It then hands the pins back and issues a one-cycle done pulse carrying the final SDA level as the result. It never forms a START or STOP condition and does not interpret any bus traffic.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, own_o, scl_oe_o and done_o are 0 and ok_o is 0.
- R2: start_i is acted on only while the sequencer is idle. A start pulse during a running sequence neither restarts nor lengthens it, and produces no extra done pulse.
- R3: If busy_i is low at some cycle of the wait window (WAIT_POLLS*HALF_CYC cycles after the start) and SDA is high in that cycle, the pins are never claimed. done_o pulses in the next cycle with ok_o = 1.
- R4: Recovery starts when busy_i is seen low together with SDA low, or when busy_i is still high in the last cycle of the wait window. From the next cycle own_o = 1 and scl_oe_o = 1 (SCL pulled low) for HALF_CYC cycles.
- R5: Each recovery pulse is HALF_CYC cycles with scl_oe_o = 0 (SCL released) followed by HALF_CYC cycles with scl_oe_o = 1.
- R6: SDA is sampled in the last cycle of every low phase (including the initial one). If it is high, no further pulse is produced.
- R7: At most MAX_PULSES pulses are produced per recovery, even if SDA never goes high.
- R8: After the last pulse, SCL is released (scl_oe_o = 0) for HALF_CYC cycles with own_o still 1. own_o then falls in the same cycle as done_o rises.
- R9: done_o is high for exactly one cycle per accepted start. ok_o then equals SDA as sampled in the last cycle of the release interval, or 1 on the path of R3, and holds its value until the next done pulse.
- R10: scl_oe_o is never 1 while own_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to run a check-and-recover sequence |
| busy_i | input | 1 | Bus-busy flag from the normal I2C controller |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | Open-drain SCL pull-down enable (1 = drive low, 0 = release) |
| own_o | output | 1 | Pin-mux select: 1 = sequencer owns SCL/SDA, 0 = controller owns them |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Result: SDA was high at the end of the last sequence |

## Verification
The assertions take for granted that sda_i and busy_i are synchronous to clk and stable around the clock edge. They also assume that start_i comes only after the internal reset synchronizer has released. The stimulus changes every input just after the falling clock edge and waits several cycles after reset before the first start. The stuck slave in the bench only reacts to rising edges of the SCL line that the block itself produces, so SDA changes only while SCL is released. Starts issued mid-sequence land inside the pulse train, never in the completion cycle.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_LEAD = 3'd2,
    ST_HIGH = 3'd3,
    ST_LOW  = 3'd4,
    ST_TAIL = 3'd5,
    ST_FIN  = 3'd6
  } unstick_state_t;

endpackage

// File: rtl/unstick_timer.sv
// Down-counting interval timer: a load of N reports expiry after N cycles.
module unstick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = val_i - W'(1);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/unstick_pulse_cnt.sv
// Counts recovery pulses and flags when the cap is reached.
module unstick_pulse_cnt #(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);

  localparam int PW = $clog2(MAX_PULSES + 1);

  logic [PW-1:0] num_q;
  logic [PW-1:0] num_d;
  logic          num_en;

  always_comb begin
    num_en = clr_i | inc_i;
    num_d  = clr_i ? '0 : (num_q + PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
    end else if (num_en) begin
      num_q <= num_d;
    end
  end

  assign at_max_o = (num_q >= PW'(MAX_PULSES));

endmodule

// File: rtl/unstick_ctrl.sv
// Sequence controller: wait window, decision, lead-low, pulse train, tail.
module unstick_ctrl
  import i2c_unstick_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int WAIT_CYC = 4000,
  parameter int TW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic          sda_i,
  input  logic          expired_i,
  input  logic          at_max_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          pcnt_clr_o,
  output logic          pcnt_inc_o,
  output logic          scl_oe_o,
  output logic          own_o,
  output logic          done_o,
  output logic          ok_o
);

  localparam logic [TW-1:0] HALF_V = TW'(HALF_CYC);
  localparam logic [TW-1:0] WAIT_V = TW'(WAIT_CYC);

  unstick_state_t state_q, state_d;
  logic           ok_q, ok_d, ok_en;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = HALF_V;
    pcnt_clr_o = 1'b0;
    pcnt_inc_o = 1'b0;
    ok_en      = 1'b0;
    ok_d       = ok_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = WAIT_V;
          pcnt_clr_o = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!busy_i && sda_i) begin
          state_d = ST_FIN;
          ok_en   = 1'b1;
          ok_d    = 1'b1;
        end else if (!busy_i || expired_i) begin
          state_d    = ST_LEAD;
          tmr_load_o = 1'b1;
        end
      end
      ST_LEAD, ST_LOW: begin
        if (expired_i) begin
          tmr_load_o = 1'b1;
          if (sda_i || at_max_i) begin
            state_d = ST_TAIL;
          end else begin
            state_d    = ST_HIGH;
            pcnt_inc_o = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (expired_i) begin
          state_d    = ST_LOW;
          tmr_load_o = 1'b1;
        end
      end
      ST_TAIL: begin
        if (expired_i) begin
          state_d = ST_FIN;
          ok_en   = 1'b1;
          ok_d    = sda_i;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= 1'b0;
    end else if (ok_en) begin
      ok_q <= ok_d;
    end
  end

  assign own_o    = (state_q == ST_LEAD) || (state_q == ST_HIGH) ||
                    (state_q == ST_LOW)  || (state_q == ST_TAIL);
  assign scl_oe_o = (state_q == ST_LEAD) || (state_q == ST_LOW);
  assign done_o   = (state_q == ST_FIN);
  assign ok_o     = ok_q;

endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick #(
  parameter int HALF_CYC   = 4,
  parameter int WAIT_POLLS = 1000,
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic own_o,
  output logic done_o,
  output logic ok_o
);

  localparam int WAIT_CYC = WAIT_POLLS * HALF_CYC;
  localparam int TMR_MAX  = (WAIT_CYC > HALF_CYC) ? WAIT_CYC : HALF_CYC;
  localparam int TW       = $clog2(TMR_MAX + 1);

  logic          rst_s1_q, rst_s2_q;
  logic          rst_int_n;
  logic          tmr_load, expired, pcnt_clr, pcnt_inc, at_max;
  logic [TW-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  unstick_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (expired)
  );

  unstick_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pcnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (pcnt_clr),
    .inc_i    (pcnt_inc),
    .at_max_o (at_max)
  );

  unstick_ctrl #(
    .HALF_CYC (HALF_CYC),
    .WAIT_CYC (WAIT_CYC),
    .TW       (TW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .busy_i     (busy_i),
    .sda_i      (sda_i),
    .expired_i  (expired),
    .at_max_i   (at_max),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .pcnt_clr_o (pcnt_clr),
    .pcnt_inc_o (pcnt_inc),
    .scl_oe_o   (scl_oe_o),
    .own_o      (own_o),
    .done_o     (done_o),
    .ok_o       (ok_o)
  );

endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int MAX_PULSES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic scl_oe_o,
  input logic own_o,
  input logic done_o,
  input logic ok_o
);

  localparam int FW = $clog2(MAX_PULSES + 3);

  logic          own_q, oe_q;
  logic [FW-1:0] rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      oe_q  <= 1'b0;
      rel_q <= '0;
    end else begin
      own_q <= own_o;
      oe_q  <= scl_oe_o;
      if (own_o && !own_q) begin
        rel_q <= '0;
      end else if (own_o && oe_q && !scl_oe_o && (rel_q != '1)) begin
        rel_q <= rel_q + FW'(1);
      end
    end
  end

  AST_OE_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe_o |-> own_o); // R10

  AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> scl_oe_o); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_FREES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!own_o && !scl_oe_o)); // R8

  AST_OWN_DROP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> done_o); // R8

  AST_OK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(ok_o)); // R9

  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q <= FW'(MAX_PULSES + 1)); // R7

endmodule

bind i2c_unstick i2c_unstick_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe_o (scl_oe_o),
  .own_o    (own_o),
  .done_o   (done_o),
  .ok_o     (ok_o)
);

// File: tb/i2c_unstick_bench.sv
`timescale 1ns/1ps
module i2c_unstick_bench;

  localparam int HALF  = 3;
  localparam int POLLS = 4;
  localparam int MAXP  = 10;
  localparam int WCYC  = HALF * POLLS;

  logic clk, rst_n, start_i, busy_i, sda_i;
  logic scl_oe_o, own_o, done_o, ok_o;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int rises = 0;
  bit stuck = 0;
  int release_n = 0;
  bit cmp_on = 0;
  bit finished = 0;
  logic scl_prev;

  logic exp_own, exp_oe, exp_done, exp_ok;

  i2c_unstick #(.HALF_CYC(HALF), .WAIT_POLLS(POLLS), .MAX_PULSES(MAXP)) u_i2c_unstick (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i), .sda_i(sda_i),
    .scl_oe_o(scl_oe_o), .own_o(own_o), .done_o(done_o), .ok_o(ok_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Stuck-slave model: holds SDA low until it has seen release_n SCL rises.
  always @(negedge clk) begin
    if (scl_prev === 1'b0 && !scl_oe_o) rises++;
    scl_prev = !scl_oe_o;
    sda_i = !stuck || (rises >= release_n);
  end

  // Behavioural reference: walks the expected sequence cycle by cycle.
  initial begin
    bit recover;
    int n;
    exp_own = 0; exp_oe = 0; exp_done = 0; exp_ok = 0;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      if (start_i) begin
        recover = 0;
        for (int i = 0; i < WCYC; i++) begin
          @(posedge clk);
          if (!busy_i) begin recover = !sda_i; break; end
          if (i == WCYC - 1) recover = 1;
        end
        if (recover) begin
          exp_own = 1; exp_oe = 1;
          repeat (HALF) @(posedge clk);
          n = 0;
          while (!sda_i && n < MAXP) begin
            n++;
            exp_oe = 0; repeat (HALF) @(posedge clk);
            exp_oe = 1; repeat (HALF) @(posedge clk);
          end
          exp_oe = 0; repeat (HALF) @(posedge clk);
          exp_ok = sda_i; exp_own = 0;
        end else begin
          exp_ok = 1;
        end
        exp_done = 1;
        @(posedge clk);
        exp_done = 0;
      end
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(own_o == exp_own, "R4/R8 own_o", own_o, exp_own);
      chk(scl_oe_o == exp_oe, "R5/R6 scl_oe_o", scl_oe_o, exp_oe);
      chk(done_o == exp_done, "R9 done_o", done_o, exp_done);
      if (done_o) begin
        done_cnt++;
        chk(ok_o == exp_ok, "R9 ok_o", ok_o, exp_ok);
      end
    end
  end

  task automatic run(input int busy_cyc, input bit stk, input int rel, input int extra_at,
                     input int want_rises, input bit want_ok, input string tag);
    int d0;
    int cyc;
    @(negedge clk); #1;
    stuck = stk; release_n = rel; rises = 0;
    @(negedge clk); #1;
    d0 = done_cnt;
    start_i = 1; busy_i = (busy_cyc > 0);
    @(negedge clk); #1;
    start_i = 0;
    cyc = 1;
    while (done_cnt == d0) begin
      if (cyc >= busy_cyc) busy_i = 0;
      if (extra_at > 0 && cyc == extra_at) start_i = 1;
      else start_i = 0;
      @(negedge clk); #1;
      cyc++;
    end
    start_i = 0; busy_i = 0;
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " R2/R9 done count"}, done_cnt - d0, 1);
    chk(rises == want_rises, {tag, " SCL rises"}, rises, want_rises);
    chk(ok_o == want_ok, {tag, " R9 result"}, ok_o, want_ok);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; busy_i = 0; sda_i = 1; scl_prev = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (5) @(negedge clk);
    chk(own_o == 0, "R1 own_o", own_o, 0);
    chk(scl_oe_o == 0, "R1 scl_oe_o", scl_oe_o, 0);
    chk(done_o == 0, "R1 done_o", done_o, 0);
    chk(ok_o == 0, "R1 ok_o", ok_o, 0);
    cmp_on = 1;
    // R3: idle bus, SDA high -> no takeover
    run(0, 0, 0, 0, 0, 1, "R3 idle bus");
    // R3: busy clears inside window, SDA high
    run(5, 0, 0, 0, 0, 1, "R3 busy clears");
    // R4 R6: SDA low, freed after 3 pulses -> 3 pulses + tail release
    run(0, 1, 3, 0, 4, 1, "R4 R6 stuck 3");
    // R4: busy never clears, SDA high -> lead low, no pulses, tail
    run(1000, 0, 0, 0, 1, 1, "R4 busy stuck");
    // R6: freed after first pulse
    run(0, 1, 1, 0, 2, 1, "R6 stuck 1");
    // R7: never freed -> capped pulses, result 0
    run(0, 1, 1000, 0, MAXP + 1, 0, "R7 never free");
    // R7: freed exactly at the last allowed pulse
    run(0, 1, MAXP, 0, MAXP + 1, 1, "R7 boundary");
    // R2: start pulse inside a running sequence is ignored
    run(0, 1, 4, 8, 5, 1, "R2 mid start");
    // R10 / R8 covered by the checker and per-cycle compare across all runs
    chk(own_o == 0 && scl_oe_o == 0, "R8 R10 pins returned", {own_o, scl_oe_o}, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule